// File: doc/BRIEF.md
# Paced Serial Transmit Byte Queue

This block buffers bytes that a host writes for a serial music-control output and releases them at a fixed slow rate. The host pushes a byte with a single write strobe. The block holds up to sixteen bytes in arrival order. Each time the pacing counter runs out on a tick, the block hands the oldest byte to the serialiser with a one-cycle strobe. A new byte is released at most once every 170 ticks.

The block also drives the transmit-request status bit through two pulses: one that sets the bit and one that clears it. The request is set when the queue drains completely. Any data write clears it. A write into a queue that is already full raises an overflow pulse. The new byte then takes the place of the oldest one, so the queue always holds the sixteen most recent bytes in order. A level-sensitive hold input empties the queue and stops draining for as long as it is high.

Top module: `tx_byte_pacer`

## Requirements
- R1: After reset the queue is empty, and `out_valid`, `ovf_pulse`, `req_set` and `req_clr` are all 0.
- R2: While `hold_rst` is 1 in a cycle, no byte is released in the next cycle. The queue is emptied, and a write in that cycle is discarded. Once hold is released and ticks run, nothing is output until a new byte is written.
- R3: A cycle with `wr_stb`=1 produces `req_clr`=1 in the following cycle, whether or not hold is active. `req_clr` is 0 in any cycle that does not follow a write.
- R4: A write into an empty queue loads the pacing counter with 169. With `tick_en` held at 1, the byte appears on `out_valid` exactly 170 cycles after the write cycle. A tick in the write cycle itself does not count.
- R5: The counter changes only on cycles with `tick_en`=1 in which the queue is non-empty and hold is low. Such a tick either decrements the counter, or, when the counter is 0, releases the oldest byte and reloads the counter to 169. Bytes leave in the order they were written.
- R6: When a release leaves the queue empty and no write occurs in the same cycle, `req_set`=1 in the same cycle as that byte's `out_valid`. `req_set` and `req_clr` are never 1 together.
- R7: A write (with hold low) into a queue that holds 16 bytes, in a cycle with no release, gives `ovf_pulse`=1 in the following cycle.
- R8: On overflow, the oldest byte is discarded and the new byte is appended, so the queue stays full and in order.
- R9: `out_valid` lasts exactly one cycle per released byte, and `out_byte` carries that byte during that cycle.
- R10: A write into a full queue in the same cycle as a release is not an overflow. The released byte leaves, and the new byte is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Pacing tick enable |
| wr_stb | input | 1 | Data-register write strobe |
| wr_byte | input | 8 | Byte written by the host |
| hold_rst | input | 1 | Transmit-reset level: flush the queue and stop draining |
| out_valid | output | 1 | One-cycle strobe for a released byte |
| out_byte | output | 8 | Released byte, valid with `out_valid` |
| ovf_pulse | output | 1 | One-cycle overflow indication |
| req_set | output | 1 | Pulse that sets the transmit-request status bit |
| req_clr | output | 1 | Pulse that clears the transmit-request status bit |

## Verification
A wrong pointer or count shows up at the first release that follows it. That release would carry the wrong byte, or it would be missing or extra. A count that is off also moves the cycle of `req_set` or of `ovf_pulse` relative to the writes. An error in the pacing counter shifts a release by one or more ticks, and a cycle-exact comparison catches that within 170 ticks. State left over after a hold shows up as an unexpected release within 170 ticks of hold being dropped.

// File: rtl/txp_pkg.sv
package txp_pkg;

    // Outcome of a host write in a given cycle
    typedef enum logic [1:0] {
        WR_NONE      = 2'd0,
        WR_APPEND    = 2'd1,
        WR_OVERWRITE = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/txp_store.sv
module txp_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/txp_pacer.sv
module txp_pacer #(
    parameter int PACE_TICKS = 170,
    localparam int CNT_W = $clog2(PACE_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,    // write into an empty queue
    input  logic run,     // qualified tick
    output logic expire   // release one byte this cycle
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PACE_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            if (cnt_q == '0) begin
                cnt_d = RELOAD;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end else if (load) begin
            cnt_d = RELOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tx_byte_pacer.sv
module tx_byte_pacer #(
    parameter int DEPTH      = 16,
    parameter int DATA_W     = 8,
    parameter int PACE_TICKS = 170
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              hold_rst,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte,
    output logic              ovf_pulse,
    output logic              req_set,
    output logic              req_clr
);
    import txp_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]  rd;
        logic [PTR_W-1:0]  wr;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [DATA_W-1:0] dout;
        logic              ovf;
        logic              set;
        logic              clr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              run, pop, load, we;
    logic [DATA_W-1:0] rd_data;
    wr_kind_e          wkind;

    assign run = tick_en && !hold_rst && (ctl_q.cnt != '0);

    always_comb begin
        if (!wr_stb || hold_rst) begin
            wkind = WR_NONE;
        end else if ((ctl_q.cnt == FULL) && !pop) begin
            wkind = WR_OVERWRITE;
        end else begin
            wkind = WR_APPEND;
        end
    end

    assign we   = (wkind != WR_NONE);
    assign load = we && (ctl_q.cnt == '0);

    txp_pacer #(.PACE_TICKS(PACE_TICKS)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .run    (run),
        .expire (pop)
    );

    txp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (ctl_q.wr),
        .wdata (wr_byte),
        .raddr (ctl_q.rd),
        .rdata (rd_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.vld  = pop;
        ctl_d.ovf  = (wkind == WR_OVERWRITE);
        ctl_d.set  = pop && (ctl_q.cnt == CNT_W'(1)) && (wkind == WR_NONE);
        ctl_d.clr  = wr_stb;

        if (pop) begin
            ctl_d.dout = rd_data;
            ctl_d.rd   = ctl_d.rd + PTR_W'(1);
        end

        if (we) begin
            ctl_d.wr = ctl_q.wr + PTR_W'(1);
        end
        if (wkind == WR_OVERWRITE) begin
            ctl_d.rd = ctl_q.rd + PTR_W'(1);
        end

        case ({wkind == WR_APPEND, pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            2'b01:   ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
            default: ctl_d.cnt = ctl_q.cnt;
        endcase

        if (hold_rst) begin
            ctl_d.rd  = '0;
            ctl_d.wr  = '0;
            ctl_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid = ctl_q.vld;
    assign out_byte  = ctl_q.dout;
    assign ovf_pulse = ctl_q.ovf;
    assign req_set   = ctl_q.set;
    assign req_clr   = ctl_q.clr;

endmodule

// File: rtl/tx_byte_pacer_sva.sv
module tx_byte_pacer_sva (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic hold_rst,
    input logic out_valid,
    input logic ovf_pulse,
    input logic req_set,
    input logic req_clr
);

    p_hold_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> !out_valid);

    p_clr_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> req_clr);

    p_set_with_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_set |-> out_valid);

    p_set_clr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_set |-> !req_clr);

    p_ovf_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(wr_stb && !hold_rst));

    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

bind tx_byte_pacer tx_byte_pacer_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .hold_rst  (hold_rst),
    .out_valid (out_valid),
    .ovf_pulse (ovf_pulse),
    .req_set   (req_set),
    .req_clr   (req_clr)
);

// File: tb/tx_byte_pacer_bench.sv
module tx_byte_pacer_bench;

    localparam int PACE = 170;
    localparam int QD   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       hold_rst = 1'b0;
    logic       out_valid, ovf_pulse, req_set, req_clr;
    logic [7:0] out_byte;

    always #2.5 clk = ~clk;

    tx_byte_pacer u_tx_byte_pacer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .hold_rst(hold_rst), .out_valid(out_valid),
        .out_byte(out_byte), .ovf_pulse(ovf_pulse), .req_set(req_set),
        .req_clr(req_clr)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    logic [7:0] mq[$];
    int         mpace = PACE - 1;
    bit         e_vld, e_ovf, e_set, e_clr;
    logic [7:0] e_byte;

    function automatic bit model_pop_due(int qsize, int pace, bit tk, bit hd);
        return tk && !hd && (qsize > 0) && (pace == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mpace = PACE - 1;
            e_vld = 0; e_ovf = 0; e_set = 0; e_clr = 0;
        end else begin
            int  pre;
            bit  pop, wr_ok;
            pre   = mq.size();
            pop   = model_pop_due(pre, mpace, tick_en, hold_rst);
            wr_ok = wr_stb && !hold_rst;
            if (tick_en && !hold_rst && pre > 0) begin
                if (pop) mpace = PACE - 1;
                else     mpace = mpace - 1;
            end
            e_vld = pop;
            if (pop) e_byte = mq.pop_front();
            e_ovf = 0;
            if (wr_ok) begin
                if (pre == QD && !pop) begin
                    e_ovf = 1;
                    void'(mq.pop_front());
                end else if (pre == 0) begin
                    mpace = PACE - 1;
                end
                mq.push_back(wr_byte);
            end
            e_set = pop && (pre == 1) && !wr_ok;
            e_clr = wr_stb;
            if (hold_rst) mq.delete();
        end
    end

    // Cycle-exact comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5/R9 out_valid", out_valid, e_vld);
            if (e_vld) chk("R5/R8 out_byte", out_byte, e_byte);
            chk("R7 ovf_pulse", ovf_pulse, e_ovf);
            chk("R6 req_set", req_set, e_set);
            chk("R3 req_clr", req_clr, e_clr);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(logic [7:0] v);
        wr_stb = 1'b1; wr_byte = v;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    initial begin
        int lat;
        int seen;
        logic [7:0] first_b, last_b;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 ovf_pulse", ovf_pulse, 0);
        chk("R1 req_set", req_set, 0);
        chk("R1 req_clr", req_clr, 0);
        rst_n = 1'b1;
        idle(2);

        // R4: latency of a byte written into an empty queue
        tick_en = 1'b1;
        push(8'h5A);
        lat = 0;
        while (!out_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        chk("R4 latency", lat, PACE);
        chk("R9 out_byte", out_byte, 8'h5A);
        chk("R6 req_set on drain", req_set, 1);
        @(negedge clk);
        chk("R9 single-cycle valid", out_valid, 0);

        // R7/R8: overflow drops the oldest byte
        tick_en = 1'b0;
        for (int i = 1; i <= 17; i++) begin
            push(8'(8'h10 + i));
            chk("R7 ovf only on 17th", ovf_pulse, (i == 17) ? 1 : 0);
        end
        tick_en = 1'b1;
        seen = 0;
        first_b = 8'h00; last_b = 8'h00;
        while (seen < 16 && cyc < 150000) begin
            @(negedge clk);
            if (out_valid) begin
                if (seen == 0) first_b = out_byte;
                last_b = out_byte;
                seen++;
            end
        end
        chk("R8 oldest dropped", first_b, 8'h12);
        chk("R8 newest kept", last_b, 8'h21);
        chk("R6 req_set after last", req_set, 1);

        // R10: write to a full queue in the release cycle
        tick_en = 1'b0;
        for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
        tick_en = 1'b1;
        idle(PACE - 1);
        push(8'h77);
        chk("R10 release", out_valid, 1);
        chk("R10 released byte", out_byte, 8'h40);
        chk("R10 no overflow", ovf_pulse, 0);

        // R2: hold flushes and discards writes
        hold_rst = 1'b1;
        @(negedge clk);
        push(8'h99);
        chk("R3 clear during hold", req_clr, 1);
        hold_rst = 1'b0;
        seen = 0;
        for (int i = 0; i < 2 * PACE; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        chk("R2 nothing after flush", seen, 0);

        // Constrained random phase
        for (int seg = 0; seg < 60; seg++) begin
            int wp = 1 + int'($urandom_range(0, 3)) * 40;
            int tp = int'($urandom_range(1, 4));
            for (int i = 0; i < 800; i++) begin
                tick_en  = ($urandom_range(0, tp) != 0);
                wr_stb   = ($urandom_range(0, wp) == 0);
                wr_byte  = 8'($urandom);
                hold_rst = ($urandom_range(0, 999) == 0);
                @(negedge clk);
            end
        end
        wr_stb = 1'b0; hold_rst = 1'b0;
        idle(4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240223));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule